// File: doc/BRIEF.md
# Sleep-Mode Clock Enable and Wake Controller

This block turns a small processor status word into the run/stop enables of the clock tree. The enables cover the core clock, the fast peripheral clock, the slow always-available clock, the fast oscillator and the bias generator that feeds it. Four sleep bits in the word select one of six operating points, from fully awake to fully dark. The enables follow the word after one register stage, so each enable changes only on a clock edge.

The block also owns the wake path. An interrupt is taken only when the global enable bit and that source's own enable bit are both set. When it is taken, the live word is copied into a one-entry save register, and the core, peripheral-clock, slow-oscillator and global-enable bits are cleared so the core can run the handler. A return strobe copies the saved word back. That puts the device back into the sleep it left, unless the handler rewrote the saved copy to stay awake. While the device is fully dark, only sources marked as external may wake it.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the status word and the saved word are zero, no acknowledge is raised, and all five enables are high.
- R2: Status word layout: bit 0 global enable, bit 1 core-off, bit 2 slow-oscillator-off, bit 3 fast-oscillator-off, bit 4 peripheral-clock-off. The core clock enable equals NOT core-off, and the peripheral clock enable equals NOT peripheral-clock-off. Both take effect one cycle after the status word changes.
- R3: The fast oscillator runs exactly when it feeds a running clock: the core clock with `mclk_src_fast` high, or the peripheral clock with `smclk_src_fast` high.
- R4: The bias generator runs when fast-oscillator-off is clear, or the fast oscillator runs, or `periph_dcgen_req` is high.
- R5: The slow clock runs when slow-oscillator-off is clear, or when it feeds a running core or peripheral clock (source select low). With all four sleep bits set and no bias request, every enable is low.
- R6: Taking an interrupt pulses a one-hot `irq_ack` for one cycle. In the same cycle it copies the live word to the saved word, and it clears core-off, peripheral-clock-off, slow-oscillator-off and global enable. Fast-oscillator-off is kept.
- R7: A request is taken only when the global enable bit is set and that source's `irq_en` bit is set.
- R8: When several requests are eligible, the lowest index wins.
- R9: While all four sleep bits are set, only sources whose bit is set in EXT_MASK are eligible (default: index 3 only).
- R10: `irq_ret` during service restores the saved word into the live word. Outside service it has no effect.
- R11: During service, `saved_wr_en` overwrites the saved word, so a handler can cancel the sleep on return. Outside service it has no effect.
- R12: No second interrupt is taken until the return strobe, even if the handler sets global enable again.
- R13: `sr_wr_en` loads the live word. When an interrupt is taken in the same cycle, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Write strobe for the live status word |
| sr_wr_data | input | SR_W | Data for the live status word |
| saved_wr_en | input | 1 | Write strobe for the saved word (service only) |
| saved_wr_data | input | SR_W | Data for the saved word |
| irq_req | input | N_IRQ | Level interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| mclk_src_fast | input | 1 | Core clock is fed by the fast oscillator (else by the slow one) |
| smclk_src_fast | input | 1 | Peripheral clock is fed by the fast oscillator (else by the slow one) |
| periph_dcgen_req | input | 1 | A peripheral needs the bias generator |
| irq_ack | output | N_IRQ | One-hot, one-cycle acknowledge |
| status_word | output | SR_W | Live status word |
| saved_word | output | SR_W | Saved status word |
| mclk_en | output | 1 | Core clock enable |
| smclk_en | output | 1 | Peripheral clock enable |
| aclk_en | output | 1 | Slow oscillator and slow clock enable |
| fosc_en | output | 1 | Fast oscillator enable |
| dcgen_en | output | 1 | Bias generator enable |

## Verification
Some properties are checked on every cycle: the acknowledge stays one-hot, and an acknowledge needs the global enable from the cycle before. An acknowledge also always leaves the awake bits cleared, while fully dark it never goes to an internal source, during service no acknowledge appears, and a return restores exactly the saved word. The enables are checked on every cycle as well: the core clock follows core-off, and the all-dark case turns every clock off. Other behaviour shows only in the bench's scenarios. These are the enable pattern of each sleep mode under different clock-source selections, the priority choice, an edited saved word taking the core back to active mode, and a write that an acknowledge in the same cycle drops.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   // status word bit positions (decoded by the core and by this block)
   localparam int B_GIE   = 0;
   localparam int B_CPUOF = 1;
   localparam int B_LFOFF = 2;
   localparam int B_FOFF  = 3;
   localparam int B_SPOFF = 4;
   localparam int MIN_SR_W = 5;

   typedef struct packed {
      logic mclk;
      logic smclk;
      logic aclk;
      logic fosc;
      logic dcgen;
   } clk_en_t;

   localparam clk_en_t EN_ALL_ON = '{mclk: 1'b1, smclk: 1'b1, aclk: 1'b1, fosc: 1'b1, dcgen: 1'b1};

   function automatic clk_en_t decode_en(input logic cpu_off, input logic lf_off,
                                         input logic f_off, input logic sp_off,
                                         input logic m_fast, input logic s_fast,
                                         input logic bias_req);
      clk_en_t e;
      e.mclk  = ~cpu_off;
      e.smclk = ~sp_off;
      e.fosc  = (e.mclk & m_fast) | (e.smclk & s_fast);
      e.aclk  = ~lf_off | (e.mclk & ~m_fast) | (e.smclk & ~s_fast);
      e.dcgen = ~f_off | e.fosc | bias_req;
      return e;
   endfunction
endpackage

// File: rtl/lpm_irq_pick.sv
module lpm_irq_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] below;
   assign below[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]   = req[i] & ~below[i];
      assign below[i+1] = below[i] | req[i];
   end
   assign any = below[N];
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
   import lpm_pkg::*;
#(
   parameter int                N_IRQ    = 4,
   parameter int                SR_W     = 8,
   parameter logic [N_IRQ-1:0]  EXT_MASK = 4'b1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sr_wr_en,
   input  logic [SR_W-1:0]  sr_wr_data,
   input  logic             saved_wr_en,
   input  logic [SR_W-1:0]  saved_wr_data,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             irq_ret,
   output logic [N_IRQ-1:0] irq_ack,
   output logic [SR_W-1:0]  sr_q,
   output logic [SR_W-1:0]  saved_q
);
   localparam logic [SR_W-1:0] WAKE_CLR = (SR_W'(1) << B_GIE) | (SR_W'(1) << B_CPUOF)
                                        | (SR_W'(1) << B_LFOFF) | (SR_W'(1) << B_SPOFF);

   logic             in_isr;
   logic             all_dark;
   logic [N_IRQ-1:0] eligible;
   logic [N_IRQ-1:0] grant;
   logic             any_req;
   logic             accept;

   assign all_dark = sr_q[B_CPUOF] & sr_q[B_LFOFF] & sr_q[B_FOFF] & sr_q[B_SPOFF];
   assign eligible = irq_req & irq_en & (all_dark ? EXT_MASK : {N_IRQ{1'b1}});

   lpm_irq_pick #(.N(N_IRQ)) u_pick (
      .req   (eligible),
      .grant (grant),
      .any   (any_req)
   );

   assign accept = any_req & sr_q[B_GIE] & ~in_isr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '0;
         saved_q <= '0;
         in_isr  <= 1'b0;
         irq_ack <= '0;
      end else begin
         irq_ack <= accept ? grant : '0;
         if (accept) begin
            saved_q <= sr_q;
            sr_q    <= sr_q & ~WAKE_CLR;
            in_isr  <= 1'b1;
         end else if (in_isr && irq_ret) begin
            sr_q   <= saved_q;
            in_isr <= 1'b0;
         end else begin
            if (sr_wr_en)
               sr_q <= sr_wr_data;
            if (in_isr && saved_wr_en)
               saved_q <= saved_wr_data;
         end
      end
   end

   // R8: one winner per acknowledge
   a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));
   // R7: acknowledge needs global enable in the accepting cycle
   a_r7_ack_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> $past(sr_q[B_GIE]));
   // R6: awake bits cleared, fast-oscillator-off bit carried over
   a_r6_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> (!sr_q[B_CPUOF] && !sr_q[B_SPOFF] && !sr_q[B_LFOFF] && !sr_q[B_GIE]
                      && sr_q[B_FOFF] == saved_q[B_FOFF]));
   // R9: fully dark wakes only from external sources
   a_r9_dark_external: assert property (@(posedge clk) disable iff (!rst_n)
      $past(all_dark) |-> ((irq_ack & ~EXT_MASK) == '0));
   // R10: return restores the saved word
   a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (in_isr && irq_ret) |=> (sr_q == $past(saved_q)));
   // R12: no nesting
   a_r12_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
      (in_isr && !irq_ret) |=> (irq_ack == '0));
endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
   import lpm_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cpu_off,
   input  logic    lf_off,
   input  logic    f_off,
   input  logic    sp_off,
   input  logic    m_fast,
   input  logic    s_fast,
   input  logic    bias_req,
   output clk_en_t en
);
   clk_en_t en_d;
   assign en_d = decode_en(cpu_off, lf_off, f_off, sp_off, m_fast, s_fast, bias_req);

   generate
      if (OUT_REG) begin : g_reg
         clk_en_t en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= EN_ALL_ON;
            else        en_q <= en_d;
         end
         assign en = en_q;

         // R2: core clock follows core-off one cycle later
         a_r2_mclk_follows: assert property (@(posedge clk) disable iff (!rst_n)
            en.mclk == !$past(cpu_off));
         // R4: bias generator held whenever its off bit is clear
         a_r4_dcgen_on: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(f_off) |-> en.dcgen);
         // R5: all sleep bits set and no bias request means dark
         a_r5_all_dark: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cpu_off && lf_off && f_off && sp_off && !bias_req) |-> (en == '0));
      end else begin : g_comb
         assign en = en_d;
      end
   endgenerate
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
   import lpm_pkg::*;
#(
   parameter int                N_IRQ    = 4,
   parameter int                SR_W     = 8,
   parameter logic [N_IRQ-1:0]  EXT_MASK = 4'b1000,
   parameter bit                OUT_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sr_wr_en,
   input  logic [SR_W-1:0]  sr_wr_data,
   input  logic             saved_wr_en,
   input  logic [SR_W-1:0]  saved_wr_data,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             irq_ret,
   input  logic             mclk_src_fast,
   input  logic             smclk_src_fast,
   input  logic             periph_dcgen_req,
   output logic [N_IRQ-1:0] irq_ack,
   output logic [SR_W-1:0]  status_word,
   output logic [SR_W-1:0]  saved_word,
   output logic             mclk_en,
   output logic             smclk_en,
   output logic             aclk_en,
   output logic             fosc_en,
   output logic             dcgen_en
);
   initial begin
      if (SR_W < MIN_SR_W) $fatal(1, "status word too narrow for the sleep bits");
      if (N_IRQ < 1)       $fatal(1, "at least one interrupt source is needed");
   end

   clk_en_t en;

   lpm_wake_ctrl #(.N_IRQ(N_IRQ), .SR_W(SR_W), .EXT_MASK(EXT_MASK)) u_wake (
      .clk           (clk),
      .rst_n         (rst_n),
      .sr_wr_en      (sr_wr_en),
      .sr_wr_data    (sr_wr_data),
      .saved_wr_en   (saved_wr_en),
      .saved_wr_data (saved_wr_data),
      .irq_req       (irq_req),
      .irq_en        (irq_en),
      .irq_ret       (irq_ret),
      .irq_ack       (irq_ack),
      .sr_q          (status_word),
      .saved_q       (saved_word)
   );

   lpm_clk_decode #(.OUT_REG(OUT_REG)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_off  (status_word[B_CPUOF]),
      .lf_off   (status_word[B_LFOFF]),
      .f_off    (status_word[B_FOFF]),
      .sp_off   (status_word[B_SPOFF]),
      .m_fast   (mclk_src_fast),
      .s_fast   (smclk_src_fast),
      .bias_req (periph_dcgen_req),
      .en       (en)
   );

   assign mclk_en  = en.mclk;
   assign smclk_en = en.smclk;
   assign aclk_en  = en.aclk;
   assign fosc_en  = en.fosc;
   assign dcgen_en = en.dcgen;
endmodule

// File: tb/sim_lpm_clk_ctrl.sv
module sim_lpm_clk_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] GIE = 8'h01, CPUOF = 8'h02, LFOFF = 8'h04, FOFF = 8'h08, SPOFF = 8'h10;
   localparam logic [7:0] M0 = CPUOF, M1 = CPUOF | FOFF, M2 = CPUOF | SPOFF,
                          M3 = CPUOF | FOFF | SPOFF, M4 = M3 | LFOFF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sr_wr_en = 0, saved_wr_en = 0, irq_ret = 0;
   logic [7:0] sr_wr_data = '0, saved_wr_data = '0;
   logic [3:0] irq_req = '0, irq_en = '0;
   logic mclk_src_fast = 1, smclk_src_fast = 1, periph_dcgen_req = 0;
   logic [3:0] irq_ack;
   logic [7:0] status_word, saved_word;
   logic mclk_en, smclk_en, aclk_en, fosc_en, dcgen_en;
   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpm_clk_ctrl u0 (.*);

   wire [4:0] en_v = {mclk_en, smclk_en, aclk_en, fosc_en, dcgen_en};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_sr(input logic [7:0] w);
      sr_wr_en = 1; sr_wr_data = w;
      @(posedge clk); #1 sr_wr_en = 0;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_ret();
      irq_ret = 1;
      @(posedge clk); #1 irq_ret = 0;
      @(negedge clk);
   endtask

   task automatic raise(input logic [3:0] r);
      irq_req = r;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 status", status_word, 0);
      chk("R1 saved", saved_word, 0);
      chk("R1 ack", irq_ack, 0);
      chk("R1 enables", en_v, 5'b11111);
   endtask

   task automatic t_modes();
      mclk_src_fast = 1; smclk_src_fast = 1;
      wr_sr(M0); chk("R2 mode0", en_v, 5'b01111);
      wr_sr(M1); chk("R3 mode1 fast periph", en_v, 5'b01111);
      wr_sr(M2); chk("R4 mode2", en_v, 5'b00101);
      wr_sr(M3); chk("R5 mode3", en_v, 5'b00100);
      wr_sr(M4); chk("R5 mode4 dark", en_v, 5'b00000);
      periph_dcgen_req = 1; @(posedge clk); @(negedge clk);
      chk("R4 bias request", en_v, 5'b00001);
      periph_dcgen_req = 0;
      wr_sr(LFOFF); chk("R5 slow off unused", en_v, 5'b11011);
      smclk_src_fast = 0;
      wr_sr(M1); chk("R3 mode1 slow periph", en_v, 5'b01100);
      wr_sr(LFOFF); chk("R5 slow off in use", en_v, 5'b11111);
      smclk_src_fast = 1;
      wr_sr(8'h00); chk("R2 active", en_v, 5'b11111);
   endtask

   task automatic t_wake();
      irq_en = 4'hF;
      wr_sr(GIE | M3);
      raise(4'b0010);
      chk("R6 ack", irq_ack, 4'b0010);
      chk("R6 awake word", status_word, FOFF);
      chk("R6 saved", saved_word, GIE | M3);
      irq_req = 0;
      @(posedge clk); @(negedge clk);
      chk("R6 ack one cycle", irq_ack, 0);
      chk("R6 clocks on", en_v, 5'b11111);
      do_ret();
      chk("R10 restore", status_word, GIE | M3);
      @(posedge clk); @(negedge clk);
      chk("R10 back asleep", en_v, 5'b00100);
   endtask

   task automatic t_edit();
      wr_sr(GIE | M0);
      raise(4'b0001); irq_req = 0;
      chk("R11 ack", irq_ack, 4'b0001);
      saved_wr_en = 1; saved_wr_data = GIE;
      @(posedge clk); #1 saved_wr_en = 0;
      @(negedge clk);
      chk("R11 saved edited", saved_word, GIE);
      do_ret();
      chk("R11 stays awake", status_word, GIE);
      @(posedge clk); @(negedge clk);
      chk("R11 core clock", mclk_en, 1);
      saved_wr_en = 1; saved_wr_data = 8'h1F;
      @(posedge clk); #1 saved_wr_en = 0;
      @(negedge clk);
      chk("R11 ignored outside", saved_word, GIE);
      do_ret();
      chk("R10 ignored outside", status_word, GIE);
   endtask

   task automatic t_gate();
      wr_sr(8'h00);
      raise(4'b0100); @(posedge clk); @(negedge clk);
      chk("R7 no gie", irq_ack, 0);
      irq_req = 0;
      wr_sr(GIE);
      irq_en = 4'b1011;
      raise(4'b0100); @(posedge clk); @(negedge clk);
      chk("R7 source disabled", irq_ack, 0);
      chk("R7 word untouched", status_word, GIE);
      irq_req = 0; irq_en = 4'hF;
   endtask

   task automatic t_prio();
      raise(4'b0110); irq_req = 0;
      chk("R8 lowest wins", irq_ack, 4'b0010);
      do_ret();
   endtask

   task automatic t_dark();
      wr_sr(GIE | M4);
      raise(4'b0001); @(posedge clk); @(negedge clk);
      chk("R9 internal blocked", irq_ack, 0);
      raise(4'b1001); irq_req = 0;
      chk("R9 external wakes", irq_ack, 4'b1000);
      do_ret();
      chk("R9 back dark", status_word, GIE | M4);
   endtask

   task automatic t_nest();
      wr_sr(GIE);
      raise(4'b0001);
      chk("R12 first ack", irq_ack, 4'b0001);
      wr_sr(GIE);
      chk("R12 no nest", irq_ack, 0);
      irq_ret = 1;
      @(posedge clk); #1 irq_ret = 0;
      @(posedge clk); @(negedge clk);
      chk("R12 after return", irq_ack, 4'b0001);
      irq_req = 0;
      do_ret();
   endtask

   task automatic t_prec();
      wr_sr(GIE);
      sr_wr_en = 1; sr_wr_data = 8'h1F; irq_req = 4'b0100;
      @(posedge clk); #1 begin sr_wr_en = 0; irq_req = 0; end
      @(negedge clk);
      chk("R13 ack wins", irq_ack, 4'b0100);
      chk("R13 write dropped", status_word, 8'h00);
      chk("R13 saved", saved_word, GIE);
      do_ret();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1;
      @(posedge clk); @(negedge clk);
      t_reset();
      t_modes();
      t_wake();
      t_edit();
      t_gate();
      t_prio();
      t_dark();
      t_nest();
      t_prec();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule